// File: doc/BRIEF.md
# Write-Protection Command Detector

This block sits between the decoded host write bus and a page-write engine. Every write strobe is checked against fixed three-step and six-step address/data command sequences. One sequence turns software write protection on, and the other turns it off. Each write is then either passed to the engine, swallowed as a command step, or turned into a dummy timed cycle. In a dummy cycle the engine runs busy, and reads act as status polling, but no data changes.

While protection is on, a page of writes goes through only when the arming sequence comes directly before it. The writes of that page must follow one another within the byte-load window of `LOAD_WIN` cycles. A gap longer than the window closes the page, and it also abandons a command sequence that is half matched. The protection bit models non-volatile storage. It starts cleared at power-up, `rstN` does not clear it, and it changes only when the engine reports that the write cycle that follows a command has finished.

Top module: `wprot_cmd_guard`

## Requirements
- R1: `protOn` is 0 at power-up. Asserting `rstN` low never changes `protOn`. `protOn` changes only on the clock edge at which `engDone` is high.
- R2: While `protOn`=0 and no sequence is in progress, a write strobe that is not a command step raises `wrAllow` in the same cycle, and `dummyReq` stays 0.
- R3: A write that matches the next expected command step never raises `wrAllow` or `dummyReq`.
- R4: The arming sequence is data AAh to address 1555h, then 55h to 0AAAh, then A0h to 1555h. If no data write follows it, `dummyReq` pulses in the cycle `LOAD_WIN` cycles after the last step. `protOn` becomes 1 at the next `engDone` and not earlier.
- R5: While `protOn`=1, a write without a prefix gives `wrAllow`=0 and `dummyReq`=1 in its own cycle, and `protOn` stays 1.
- R6: While `protOn`=1, writes that follow the arming sequence, each within `LOAD_WIN` cycles of the one before, get `wrAllow`=1. When such a page closes, `dummyReq` stays 0, and `protOn` is still 1 after `engDone`.
- R7: The disarming sequence is AAh@1555h, 55h@0AAAh, 80h@1555h, AAh@1555h, 55h@0AAAh, 20h@1555h. After it, `protOn` becomes 0 at the next `engDone`.
- R8: A write that does not match the next expected step sends the matcher back to idle. That same write is then handled as an ordinary write.
- R9: If more than `LOAD_WIN` cycles pass between two command steps, the sequence is abandoned, and the later write is handled as an ordinary write.
- R10: Strobes that arrive while `engBusy`=1 get neither `wrAllow` nor `dummyReq`, and they leave the matcher state as it was.
- R11: The command addresses 1555h and 0AAAh stay writable with ordinary data (for example 12h@1555h gets `wrAllow`=1 while unprotected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the sequence state; leaves protection alone |
| wrStb | input | 1 | One-cycle decoded write strobe |
| wrAddr | input | 13 | Write address |
| wrData | input | 8 | Write data |
| engBusy | input | 1 | Page-write engine is running a timed cycle |
| engDone | input | 1 | One-cycle pulse when the engine's timed cycle ends |
| wrAllow | output | 1 | Pass the current write to the engine's page latch |
| dummyReq | output | 1 | Start a timed cycle that writes no data |
| protOn | output | 1 | Software write protection is active |

## Verification
The bench aims at the boundaries of the load window. A step that comes after the window has run out must be treated as ordinary data. A detector that kept its partial match would arm protection on a late byte. The bench holds the arming sequence open across a strobe that arrives while the engine is busy; a design that counted that strobe as a mismatch would never arm. It also checks that `protOn` waits for `engDone` and survives a reset pulse. A design that switched protection at the end of the sequence, or that cleared it on reset, fails that check. Random stimulus with and without protection shows that no ordinary write slips through while protected and that none is blocked while unprotected.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 8;
  localparam int SEQ_LEN  = 6;
  localparam int STEP_W   = $clog2(SEQ_LEN);
  localparam int ARM_STEP = 2;

  typedef enum logic [1:0] {PEND_NONE, PEND_ARM, PEND_DISARM} pend_t;

  typedef struct packed {
    logic gapClr;
    logic gapRun;
  } gapCtl_t;

  // Expected address of each step of the long (disarm) sequence
  function automatic logic [ADDR_W-1:0] stepAddr(input logic [STEP_W-1:0] idx);
    return (idx == 3'd1 || idx == 3'd4) ? ADDR_W'(16'h0AAA) : ADDR_W'(16'h1555);
  endfunction

  // Expected data of each step of the long (disarm) sequence
  function automatic logic [DATA_W-1:0] stepData(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2:       return 8'h80;
      default:    return 8'h20;
    endcase
  endfunction

  localparam logic [DATA_W-1:0] ARM_DATA = 8'hA0;
endpackage

// File: rtl/wpc_datapath.sv
module wpc_datapath
  import wpc_pkg::*;
#(
  parameter int LOAD_WIN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [STEP_W-1:0] stepIdx,
  input  gapCtl_t           gapCtl,
  output logic              hitStep,
  output logic              hitArm,
  output logic              gapExp
);
  localparam int GAP_W = $clog2(LOAD_WIN + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LOAD_WIN - 1);

  logic [GAP_W-1:0] gapCnt;

  always_comb begin
    hitStep = (wrAddr == stepAddr(stepIdx)) && (wrData == stepData(stepIdx));
    hitArm  = (stepIdx == STEP_W'(ARM_STEP)) && (wrAddr == stepAddr(stepIdx))
              && (wrData == ARM_DATA);
    gapExp  = (gapCnt == GAP_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (gapCtl.gapClr) begin
      gapCnt <= '0;
    end else if (gapCtl.gapRun && gapCnt != GAP_LAST) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R9
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= GAP_LAST);

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx < STEP_W'(SEQ_LEN));
endmodule

// File: rtl/wpc_control.sv
module wpc_control
  import wpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic              hitStep,
  input  logic              hitArm,
  input  logic              gapExp,
  output logic [STEP_W-1:0] stepIdx,
  output gapCtl_t           gapCtl,
  output logic              wrAllow,
  output logic              dummyReq,
  output logic              protOn
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  logic              pageOpen, pageData, waitDone;
  pend_t             pend;
  logic [STEP_W-1:0] stepN;
  logic              pageOpenN, pageDataN, waitDoneN, protN;
  pend_t             pendN;
  logic              accept, active, expire;

  // protection storage: power-up value only, never touched by rstN
  logic protReg = 1'b0;
  assign protOn = protReg;

  always_comb begin
    accept    = wrStb && !engBusy;
    active    = pageOpen || (stepIdx != '0);
    expire    = active && !accept && gapExp;
    stepN     = stepIdx;
    pageOpenN = pageOpen;
    pageDataN = pageData;
    waitDoneN = waitDone;
    pendN     = pend;
    protN     = protReg;
    wrAllow   = 1'b0;
    dummyReq  = 1'b0;
    gapCtl.gapClr = !active;
    gapCtl.gapRun = active;

    if (accept) begin
      if (pageOpen) begin
        wrAllow       = 1'b1;
        pageDataN     = 1'b1;
        gapCtl.gapClr = 1'b1;
      end else if (hitArm) begin
        stepN         = '0;
        pageOpenN     = 1'b1;
        pageDataN     = 1'b0;
        pendN         = PEND_ARM;
        gapCtl.gapClr = 1'b1;
      end else if (hitStep) begin
        gapCtl.gapClr = 1'b1;
        if (stepIdx == LAST_STEP) begin
          stepN     = '0;
          pageOpenN = 1'b1;
          pageDataN = 1'b0;
          pendN     = PEND_DISARM;
        end else begin
          stepN = stepIdx + 1'b1;
        end
      end else begin
        stepN    = '0;
        wrAllow  = !protReg;
        dummyReq = protReg;
      end
    end else if (expire) begin
      stepN = '0;
      if (pageOpen) begin
        pageOpenN = 1'b0;
        waitDoneN = 1'b1;
        dummyReq  = !pageData;
      end
    end

    if (waitDone && engDone) begin
      waitDoneN = 1'b0;
      protN     = (pend == PEND_ARM);
      pendN     = PEND_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx  <= '0;
      pageOpen <= 1'b0;
      pageData <= 1'b0;
      waitDone <= 1'b0;
      pend     <= PEND_NONE;
    end else begin
      stepIdx  <= stepN;
      pageOpen <= pageOpenN;
      pageData <= pageDataN;
      waitDone <= waitDoneN;
      pend     <= pendN;
    end
  end

  always_ff @(posedge clk) begin
    protReg <= rstN ? protN : protReg;
  end

  // R1
  prot_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protReg) |-> $past(engDone));

  // R4
  arm_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protReg) |-> $past(pend) == PEND_ARM);

  // R5
  guarded_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrAllow |-> (!protReg || pageOpen));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    engBusy |-> !wrAllow);
endmodule

// File: rtl/wprot_cmd_guard.sv
module wprot_cmd_guard
  import wpc_pkg::*;
#(
  parameter int LOAD_WIN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              engBusy,
  input  logic              engDone,
  output logic              wrAllow,
  output logic              dummyReq,
  output logic              protOn
);
  logic [STEP_W-1:0] stepIdx;
  gapCtl_t           gapCtl;
  logic              hitStep, hitArm, gapExp;

  wpc_datapath #(.LOAD_WIN(LOAD_WIN)) u_dp (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .stepIdx(stepIdx), .gapCtl(gapCtl),
    .hitStep(hitStep), .hitArm(hitArm), .gapExp(gapExp)
  );

  wpc_control u_ctl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .engBusy(engBusy),
    .engDone(engDone), .hitStep(hitStep), .hitArm(hitArm), .gapExp(gapExp),
    .stepIdx(stepIdx), .gapCtl(gapCtl),
    .wrAllow(wrAllow), .dummyReq(dummyReq), .protOn(protOn)
  );
endmodule

// File: tb/wprot_cmd_guard_bench.sv
module wprot_cmd_guard_bench;
  localparam int LOAD_WIN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        engBusy = 1'b0;
  logic        engDone = 1'b0;
  logic        wrAllow, dummyReq, protOn;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  wprot_cmd_guard #(.LOAD_WIN(LOAD_WIN)) u_wprot_cmd_guard (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .engBusy(engBusy), .engDone(engDone),
    .wrAllow(wrAllow), .dummyReq(dummyReq), .protOn(protOn)
  );

  function automatic bit isFirstStep(input logic [12:0] a, input logic [7:0] d);
    return (a == 13'h1555) && (d == 8'hAA);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one strobe from a negedge, check its same-cycle outputs, return at next negedge
  task automatic doWr(input logic [12:0] a, input logic [7:0] d,
                      input bit expAllow, input bit expDummy, input string req);
    wrStb = 1'b1; wrAddr = a; wrData = d;
    #1;
    chk({req, " wrAllow"}, {31'd0, wrAllow}, {31'd0, expAllow});
    chk({req, " dummyReq"}, {31'd0, dummyReq}, {31'd0, expDummy});
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  // Wait out the load window after the last strobe and check the expiry pulse
  task automatic expireWin(input bit expDummy, input string req);
    repeat (LOAD_WIN - 1) @(negedge clk);
    #1;
    chk({req, " expiry dummyReq"}, {31'd0, dummyReq}, {31'd0, expDummy});
    @(negedge clk);
  endtask

  task automatic engineCycle(input bit expBefore, input bit expAfter, input string req);
    engBusy = 1'b1;
    repeat (3) @(negedge clk);
    chk({req, " protOn before done"}, {31'd0, protOn}, {31'd0, expBefore});
    engBusy = 1'b0; engDone = 1'b1;
    @(negedge clk);
    engDone = 1'b0;
    #1;
    chk({req, " protOn after done"}, {31'd0, protOn}, {31'd0, expAfter});
    @(negedge clk);
  endtask

  task automatic armSeq(input string req);
    doWr(13'h1555, 8'hAA, 1'b0, 1'b0, req);
    doWr(13'h0AAA, 8'h55, 1'b0, 1'b0, req);
    doWr(13'h1555, 8'hA0, 1'b0, 1'b0, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    int seedVal;
    seedVal = $urandom(32'h5eed);
    #1;
    // R1 power-up state
    chk("R1 protOn at power-up", {31'd0, protOn}, 32'd0);
    chk("R1 wrAllow in reset", {31'd0, wrAllow}, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 command address used for ordinary data
    doWr(13'h1555, 8'h12, 1'b1, 1'b0, "R11");
    doWr(13'h0AAA, 8'hAA, 1'b1, 1'b0, "R11");

    // R2 random unprotected traffic, some during busy (R10)
    for (int i = 0; i < 40; i++) begin
      logic [12:0] a;
      logic [7:0]  d;
      bit          busy;
      a = 13'($urandom);
      d = 8'($urandom);
      if (i % 5 == 0) a = 13'h1555;
      if (isFirstStep(a, d)) d = 8'h11;
      busy = ($urandom % 4) == 0;
      engBusy = busy;
      doWr(a, d, !busy, 1'b0, busy ? "R10" : "R2");
      engBusy = 1'b0;
    end

    // R3 / R8 mismatch after a started sequence
    doWr(13'h1555, 8'hAA, 1'b0, 1'b0, "R3");
    doWr(13'h0AAA, 8'h77, 1'b1, 1'b0, "R8");
    doWr(13'h1555, 8'hA0, 1'b1, 1'b0, "R8");

    // R9 gap longer than the load window abandons the sequence
    doWr(13'h1555, 8'hAA, 1'b0, 1'b0, "R9");
    doWr(13'h0AAA, 8'h55, 1'b0, 1'b0, "R9");
    repeat (LOAD_WIN) @(negedge clk);
    doWr(13'h1555, 8'hA0, 1'b1, 1'b0, "R9");
    chk("R9 protOn", {31'd0, protOn}, 32'd0);

    // R4 arm with no data page
    armSeq("R4");
    expireWin(1'b1, "R4");
    engineCycle(1'b0, 1'b1, "R4");

    // R1 reset leaves protection set
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 protOn after reset", {31'd0, protOn}, 32'd1);
    @(negedge clk);

    // R5 random protected traffic without prefix
    for (int i = 0; i < 40; i++) begin
      logic [12:0] a;
      logic [7:0]  d;
      bit          busy;
      a = 13'($urandom);
      d = 8'($urandom);
      if (isFirstStep(a, d)) d = 8'h00;
      busy = ($urandom % 4) == 0;
      engBusy = busy;
      doWr(a, d, 1'b0, !busy, busy ? "R10" : "R5");
      engBusy = 1'b0;
    end
    chk("R5 protOn kept", {31'd0, protOn}, 32'd1);

    // R6 prefixed page while protected
    armSeq("R6");
    doWr(13'h0100, 8'h3C, 1'b1, 1'b0, "R6");
    repeat (3) @(negedge clk);
    doWr(13'h0101, 8'hC3, 1'b1, 1'b0, "R6");
    doWr(13'h1555, 8'hAA, 1'b1, 1'b0, "R6");
    expireWin(1'b0, "R6");
    engineCycle(1'b1, 1'b1, "R6");
    doWr(13'h0102, 8'h5A, 1'b0, 1'b1, "R6 page closed");

    // R7 disarm
    doWr(13'h1555, 8'hAA, 1'b0, 1'b0, "R7");
    doWr(13'h0AAA, 8'h55, 1'b0, 1'b0, "R7");
    doWr(13'h1555, 8'h80, 1'b0, 1'b0, "R7");
    doWr(13'h1555, 8'hAA, 1'b0, 1'b0, "R7");
    doWr(13'h0AAA, 8'h55, 1'b0, 1'b0, "R7");
    doWr(13'h1555, 8'h20, 1'b0, 1'b0, "R7");
    expireWin(1'b1, "R7");
    engineCycle(1'b1, 1'b0, "R7");
    doWr(13'h0200, 8'h99, 1'b1, 1'b0, "R7 unprotected");

    // R10 busy strobe inside a sequence leaves the match intact
    doWr(13'h1555, 8'hAA, 1'b0, 1'b0, "R10");
    doWr(13'h0AAA, 8'h55, 1'b0, 1'b0, "R10");
    engBusy = 1'b1;
    doWr(13'h0000, 8'h33, 1'b0, 1'b0, "R10 busy strobe");
    engBusy = 1'b0;
    doWr(13'h1555, 8'hA0, 1'b0, 1'b0, "R10 final step");
    expireWin(1'b1, "R10");
    engineCycle(1'b0, 1'b1, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule